// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two buses, called A and B, through a set of independent byte-wide sections. Each section holds two storage registers, one for each direction of transfer. Each direction has a source select that picks either the live value of the opposite bus or the value held in that direction's register. Each direction also has its own driver enable. The drive toward B is enabled by a high level and the drive toward A by a low level. A register loads its bus on any clock edge where its capture strobe is high, whatever the enables and selects are.

For synthesis, each bus is split into an input vector (the resolved bus value), an output vector and a per-bit output-enable vector. A two-way live connection would be a combinational loop. In that mode, each bus instead drives its own value from the previous clock edge through a per-bit keeper register. A line that every external driver has released therefore holds its last value. Outputs are combinational; only the storage and keeper registers are clocked.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A clock edge with `rst_n` low clears both storage registers and both keepers of every section to zero.
- R2: A clock edge with `cap_ab[s]` high loads section s of `a_in` into that section's A-to-B register. A clock edge with `cap_ba[s]` high loads section s of `b_in` into its B-to-A register. Enable and select values have no effect on either load.
- R3: `b_oe` bits of section s equal `en_ab[s]`, and `a_oe` bits equal the inverse of `en_ba_n[s]`. An output whose enable is off reads zero.
- R4: When driving and not in reinforce mode, `sel_ab[s]`=0 puts the live `a_in` section on `b_out` and `sel_ab[s]`=1 puts the A-to-B register there. `sel_ba[s]` selects between `b_in` and the B-to-A register for `a_out` in the same way.
- R5: With `en_ab[s]`=0 and `en_ba_n[s]`=1 the section drives neither bus, and captures still load.
- R6: With `en_ab[s]`=1, `en_ba_n[s]`=0 and both selects 1, the section drives both stored values at once: A-to-B onto B and B-to-A onto A.
- R7: Reinforce mode is `en_ab[s]`=1, `en_ba_n[s]`=0 and both selects 0. In this mode `a_out` equals `a_in` from the previous clock edge and `b_out` equals `b_in` from the previous edge, so released lines hold their last value.
- R8: The controls of one section change neither the outputs nor the registers of any other section.
- R9: With the A-to-B select high and A driving B, a capture into both registers on the same edge loads the old A-to-B contents into the B-to-A register. Staggered captures, A-to-B first, load the new value into both. With the select low, a single shared edge loads the A value into both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage and keeper registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Resolved value of bus A |
| a_out | output | 16 | Value this block drives onto bus A |
| a_oe | output | 16 | Per-bit drive enable for bus A |
| b_in | input | 16 | Resolved value of bus B |
| b_out | output | 16 | Value this block drives onto bus B |
| b_oe | output | 16 | Per-bit drive enable for bus B |
| en_ab | input | 2 | Per-section enable of drive onto B, active high |
| en_ba_n | input | 2 | Per-section enable of drive onto A, active low |
| sel_ab | input | 2 | Per-section B-side source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-section A-side source: 0 live B, 1 stored |
| cap_ab | input | 2 | Per-section load strobe for the A-to-B register |
| cap_ba | input | 2 | Per-section load strobe for the B-to-A register |

## Verification
The bench targets four corner cases. The first is captures made while a section is isolated or driving the other way. A design that gated loads with the enables would later read back stale contents. The second is reinforce mode after the external drivers let go. A design that passed live data across would loop or return the opposite bus's value rather than each bus's own last value. The third is the same-edge double capture with the select high, where the B-to-A register must receive the old stored word. The fourth is mixed controls across the two sections, where a decode that leaked between sections would show up in the other byte.

// File: rtl/xcvr_pkg.sv
// Package: shared sizing and mode decode for the registered transceiver.
// Assumes every section has the same width.
package xcvr_pkg;
    localparam int XCVR_SECTIONS = 2;
    localparam int XCVR_SECT_W   = 8;

    // Drive mode of one section, decoded from its enables and selects.
    typedef enum logic [1:0] {
        XM_NORMAL    = 2'd0,
        XM_REINFORCE = 2'd1
    } xcvr_mode_e;

    // Reinforce applies only when both directions drive live data.
    function automatic xcvr_mode_e xcvr_decode(input logic en_ab, input logic en_ba_n,
                                               input logic sel_ab, input logic sel_ba);
        if (en_ab && !en_ba_n && !sel_ab && !sel_ba)
            return XM_REINFORCE;
        return XM_NORMAL;
    endfunction
endpackage

// File: rtl/xcvr_store_reg.sv
// Module: one direction's storage register.
// It loads d on a clock edge with load high and holds otherwise.
// Assumes a synchronous active-low reset to zero.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the bus on a strobed edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/xcvr_bus_keeper.sv
// Module: per-bit keeper that remembers a bus's value at the last clock edge.
// Reinforce mode drives this value back onto the bus, so no live loop exists.
module xcvr_bus_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus,
    output logic [W-1:0] held
);
    // Sample the resolved bus on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else
            held <= bus;
    end

    // R7
    keeper_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (held == $past(bus)));
endmodule

// File: rtl/xcvr_section.sv
// Module: one byte-wide transceiver section.
// It has two storage registers, two bus keepers, source muxes and enable gating.
// Assumes a_in and b_in are the resolved bus values seen at the pins.
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_SECT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_ab,
    input  logic         cap_ba
);
    logic [W-1:0] stored_ab, stored_ba;
    logic [W-1:0] kept_a, kept_b;
    logic [W-1:0] src_b, src_a;
    xcvr_mode_e   mode;

    xcvr_store_reg #(.W(W)) u_reg_ab (
        .clk(clk), .rst_n(rst_n), .load(cap_ab), .d(a_in), .q(stored_ab));

    xcvr_store_reg #(.W(W)) u_reg_ba (
        .clk(clk), .rst_n(rst_n), .load(cap_ba), .d(b_in), .q(stored_ba));

    xcvr_bus_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst_n(rst_n), .bus(a_in), .held(kept_a));

    xcvr_bus_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst_n(rst_n), .bus(b_in), .held(kept_b));

    // Decode whether this section is in two-way live mode.
    always_comb mode = xcvr_decode(en_ab, en_ba_n, sel_ab, sel_ba);

    // Choose what each direction would drive.
    always_comb begin
        if (mode == XM_REINFORCE) begin
            src_b = kept_b;
            src_a = kept_a;
        end else begin
            src_b = sel_ab ? stored_ab : a_in;
            src_a = sel_ba ? stored_ba : b_in;
        end
    end

    // Gate the drivers with their enables; idle outputs read zero.
    always_comb begin
        b_oe  = {W{en_ab}};
        a_oe  = {W{~en_ba_n}};
        b_out = en_ab    ? src_b : '0;
        a_out = !en_ba_n ? src_a : '0;
    end

    // R3
    b_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == '0) |-> (b_out == '0));

    // R3
    a_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe == '0) |-> (a_out == '0));
endmodule

// File: rtl/dual_reg_xcvr.sv
// Module: top of the registered transceiver.
// It replicates one section per byte of the buses.
// Assumes the bus width is SECTIONS * SECT_W and that each control bit drives one section.
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int SECTIONS = XCVR_SECTIONS,
    parameter int SECT_W   = XCVR_SECT_W,
    localparam int BUS_W   = SECTIONS * SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    a_in,
    output logic [BUS_W-1:0]    a_out,
    output logic [BUS_W-1:0]    a_oe,
    input  logic [BUS_W-1:0]    b_in,
    output logic [BUS_W-1:0]    b_out,
    output logic [BUS_W-1:0]    b_oe,
    input  logic [SECTIONS-1:0] en_ab,
    input  logic [SECTIONS-1:0] en_ba_n,
    input  logic [SECTIONS-1:0] sel_ab,
    input  logic [SECTIONS-1:0] sel_ba,
    input  logic [SECTIONS-1:0] cap_ab,
    input  logic [SECTIONS-1:0] cap_ba
);
    // One independent section per byte slice.
    for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
        xcvr_section #(.W(SECT_W)) u_sect (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_in    (a_in [s*SECT_W +: SECT_W]),
            .a_out   (a_out[s*SECT_W +: SECT_W]),
            .a_oe    (a_oe [s*SECT_W +: SECT_W]),
            .b_in    (b_in [s*SECT_W +: SECT_W]),
            .b_out   (b_out[s*SECT_W +: SECT_W]),
            .b_oe    (b_oe [s*SECT_W +: SECT_W]),
            .en_ab   (en_ab[s]),
            .en_ba_n (en_ba_n[s]),
            .sel_ab  (sel_ab[s]),
            .sel_ba  (sel_ba[s]),
            .cap_ab  (cap_ab[s]),
            .cap_ba  (cap_ba[s])
        );
    end
endmodule

// File: tb/dual_reg_xcvr_tb.sv
// Bench: resolves both buses from the block's enables and an external driver.
// It clears external drive wherever the block drives, and checks against a bench model.
module dual_reg_xcvr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int W  = 8;
    localparam int BW = NS * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;
    logic [NS-1:0] en_ab = '0, en_ba_n = '1, sel_ab = '0, sel_ba = '0, cap_ab = '0, cap_ba = '0;
    logic [BW-1:0] ext_a = '0, ext_b = '0, ext_a_en = '0, ext_b_en = '0;
    logic [BW-1:0] m_rab = '0, m_rba = '0, m_ka = '0, m_kb = '0;
    logic [BW-1:0] exp_a_out, exp_b_out, exp_a_oe, exp_b_oe;
    int checks = 0;
    int errors = 0;

    dual_reg_xcvr dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .cap_ab(cap_ab), .cap_ba(cap_ba)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [BW-1:0] spread(input logic [NS-1:0] c);
        logic [BW-1:0] r;
        for (int s = 0; s < NS; s++) r[s*W +: W] = {W{c[s]}};
        return r;
    endfunction

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Resolve the buses from the model and the external drivers, with no contention.
    task automatic resolve();
        logic [BW-1:0] oa, ob, rf, sa, sb, da, db, ba, bb;
        oa = spread(~en_ba_n);
        ob = spread(en_ab);
        rf = spread(en_ab & ~en_ba_n & ~sel_ab & ~sel_ba);
        sa = spread(sel_ab);
        sb = spread(sel_ba);
        ext_a_en = ext_a_en & ~oa;
        ext_b_en = ext_b_en & ~ob;
        da = (rf & m_ka) | (~rf & sb & m_rba);
        db = (rf & m_kb) | (~rf & sa & m_rab);
        ba = '0;
        bb = '0;
        for (int i = 0; i < 3; i++) begin
            ba = (ext_a_en & ext_a) | (~ext_a_en & oa & da);
            bb = (ext_b_en & ext_b) | (~ext_b_en & ob & db);
            da = (rf & m_ka) | (~rf & sb & m_rba) | (~rf & ~sb & bb);
            db = (rf & m_kb) | (~rf & sa & m_rab) | (~rf & ~sa & ba);
        end
        a_in = ba;
        b_in = bb;
        exp_a_out = oa & da;
        exp_b_out = ob & db;
        exp_a_oe  = oa;
        exp_b_oe  = ob;
    endtask

    // One cycle: resolve, check between edges, then advance the model at the edge.
    task automatic step(input string tag, input bit do_check);
        logic [BW-1:0] n_rab, n_rba, cab, cba;
        resolve();
        #1;
        if (do_check) begin
            check({tag, " a_out"}, a_out, exp_a_out);
            check({tag, " b_out"}, b_out, exp_b_out);
            check("R3 a_oe", a_oe, exp_a_oe);
            check("R3 b_oe", b_oe, exp_b_oe);
        end
        cab = spread(cap_ab);
        cba = spread(cap_ba);
        n_rab = (cab & a_in) | (~cab & m_rab);
        n_rba = (cba & b_in) | (~cba & m_rba);
        @(posedge clk);
        if (!rst_n) begin
            m_rab = '0; m_rba = '0; m_ka = '0; m_kb = '0;
        end else begin
            m_rab = n_rab; m_rba = n_rba; m_ka = a_in; m_kb = b_in;
        end
        @(negedge clk);
    endtask

    task automatic ctrl(input logic [NS-1:0] eab, input logic [NS-1:0] eban,
                        input logic [NS-1:0] sab, input logic [NS-1:0] sba,
                        input logic [NS-1:0] cab, input logic [NS-1:0] cba);
        en_ab = eab; en_ba_n = eban; sel_ab = sab; sel_ba = sba; cap_ab = cab; cap_ba = cba;
    endtask

    task automatic ext(input logic [BW-1:0] av, input logic [BW-1:0] aen,
                       input logic [BW-1:0] bv, input logic [BW-1:0] ben);
        ext_a = av; ext_a_en = aen; ext_b = bv; ext_b_en = ben;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        @(negedge clk);
        // Reset edges with captures and external drive active; model clears.
        ctrl('1, '1, '0, '0, '1, '1);
        ext(16'hFFFF, '1, 16'hFFFF, '1);
        step("R1", 1'b0);
        step("R1", 1'b0);
        // R1: stored readout of both registers right after reset is zero.
        ctrl('1, '0, '1, '1, '0, '0);
        ext('0, '0, '0, '0);
        step("R1", 1'b1);
        rst_n = 1'b1;
        step("R1", 1'b1);

        // R5: isolated section still captures.
        ctrl('0, '1, '0, '0, '1, '1);
        ext(16'h5A3C, '1, 16'h1234, '1);
        step("R5", 1'b1);
        // R2 and R6: read both stored words back at once.
        ctrl('1, '0, '1, '1, '0, '0);
        ext('0, '0, '0, '0);
        step("R2", 1'b1);
        step("R6", 1'b1);

        // R7: bus values set while isolated, then held by reinforce after release.
        ctrl('0, '1, '0, '0, '0, '0);
        ext(16'hC3C3, '1, 16'h0F0F, '1);
        step("R5", 1'b1);
        ctrl('1, '0, '0, '0, '0, '0);
        ext('0, '0, '0, '0);
        step("R7", 1'b1);
        step("R7", 1'b1);

        // R8: section 0 drives stored words, section 1 isolated and capturing.
        ctrl(2'b01, 2'b10, 2'b01, 2'b01, 2'b10, 2'b10);
        ext(16'hAB00, 16'hFF00, 16'hCD00, 16'hFF00);
        step("R8", 1'b1);
        ctrl(2'b10, 2'b01, 2'b10, 2'b10, 2'b00, 2'b00);
        ext('0, '0, '0, '0);
        step("R8", 1'b1);

        // R9: select high, shared edge gives old stored word to B-to-A register.
        ctrl('1, '1, '1, '0, '1, '1);
        ext(16'h7777, '1, '0, '0);
        step("R9", 1'b1);
        ctrl('0, '0, '0, '1, '0, '0);
        ext('0, '0, '0, '0);
        step("R9", 1'b1);
        // R9: staggered captures with select high load the new word into both.
        ctrl('1, '1, '1, '0, '1, '0);
        ext(16'h6161, '1, '0, '0);
        step("R9", 1'b1);
        ctrl('1, '1, '1, '0, '0, '1);
        step("R9", 1'b1);
        ctrl('1, '0, '1, '1, '0, '0);
        ext('0, '0, '0, '0);
        step("R9", 1'b1);
        // R9: select low lets one shared edge load both.
        ctrl('1, '1, '0, '0, '1, '1);
        ext(16'h9999, '1, '0, '0);
        step("R9", 1'b1);
        ctrl('1, '0, '1, '1, '0, '0);
        ext('0, '0, '0, '0);
        step("R9", 1'b1);

        // R4: random controls and data across all modes.
        for (int n = 0; n < 600; n++) begin
            ctrl(NS'($urandom), NS'($urandom), NS'($urandom), NS'($urandom),
                 NS'($urandom), NS'($urandom));
            ext(BW'($urandom), BW'($urandom), BW'($urandom), BW'($urandom));
            step("R4", 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule